// File: doc/BRIEF.md
# Write-Masked Clock Select and Divider

This block holds the clock-control word for a processor clock domain and runs the small datapath behind it. It picks one of two parent clocks, a primary and an alternate, and divides the chosen one by a programmable integer. Both parents arrive as single-cycle enable pulses on the system clock. The result leaves as a single-cycle enable pulse, `clkEnOut`.

Software writes 32-bit words. The upper half of each word is a per-bit write enable for the lower half. One write can change the parent select and the divisor together, or either one alone, with no read-modify-write. When the parent changes, the old parent is gated off first. Two synchronising cycles follow, and only then is the new parent admitted. The divisor written in the same word goes into effect at exactly that moment. A divisor-only change waits for the end of the current output period.

Top module: `clk_sel_div`

## Requirements
- R1: After reset the control word reads 0: the primary parent is active (`selActive` = 0) with a divisor field of 0, so each primary pulse gives one `clkEnOut` pulse one cycle later.
- R2: A write updates data bit n (n = 0..15) only when `wrData[n+16]` is 1. Bits whose enable is 0 keep their value, and the word does not change when no write occurs.
- R3: `rdData[15:0]` returns the current control word and `rdData[31:16]` is always zero.
- R4: The divisor field is bits [3:0]. With field value d, `clkEnOut` pulses once for every d+1 pulses of the active parent, in the cycle after the (d+1)th pulse. This holds up to the maximum of 15 (divide by 16).
- R5: Bit 6 selects the parent: 0 is primary and 1 is alternate. Pulses of the parent that is not active never advance the divider.
- R6: On a change of bit 6, no `clkEnOut` pulse appears for the three cycles after the write edge. `selActive` takes the new value on the third clock edge after the write edge, and `clkEnOut` is low in the cycle where `selActive` changes and in the cycle before it.
- R7: When bit 6 and the divisor change in one write, the old parent finishes with the old divisor. The first pulse of the new parent already counts toward the new divisor, starting a fresh period.
- R8: A divisor-only write does not cut the current output period short. That period completes with the old divisor, and the new value governs the periods after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | [31:16] per-bit enables, [15:0] data |
| rdData | output | 32 | Control word in [15:0], zeros above |
| priEn | input | 1 | Primary parent clock enable pulse |
| altEn | input | 1 | Alternate parent clock enable pulse |
| clkEnOut | output | 1 | Divided output clock enable pulse |
| selActive | output | 1 | Parent currently feeding the divider (0 primary) |

## Verification
The bench changes the parent and the divisor in one word while both parents pulse every cycle. A design that loaded the divisor early would divide the old parent by the new value. One that loaded it late would let the first new-parent pulse produce an output immediately. Mid-period divisor writes catch a design that reloads at once and emits a runt period. Masked writes with partial, empty and full enables catch a write path that ignores the enable half or clears unenabled bits. The handoff window is sampled cycle by cycle, so a design that admits the new parent early, or lets the old one leak through, shows up.

// File: rtl/clk_sel_div_pkg.sv
package clk_sel_div_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic gateOn;   // active parent may reach the divider
    logic commit;   // end of handoff: swap parent, load divisor, clear count
    logic nextSel;  // parent chosen at commit
  } ctrl_stb_t;

  typedef enum logic [1:0] {
    HS_RUN   = 2'd0,
    HS_SYNC1 = 2'd1,
    HS_SYNC2 = 2'd2
  } handoff_t;
endpackage

// File: rtl/clk_sel_div_ctrl.sv
module clk_sel_div_ctrl
  import clk_sel_div_pkg::*;
#(
  parameter int DIV_SHIFT = 0,
  parameter int DIV_WIDTH = 4,
  parameter int MUX_SHIFT = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [31:0]          wrData,
  input  logic                 actSel,
  output logic [15:0]          ctlWord,
  output logic [DIV_WIDTH-1:0] cfgDiv,
  output ctrl_stb_t            stb
);
  localparam int DATA_W = 16;

  logic [DATA_W-1:0] regQ;
  logic [DATA_W-1:0] regNext;
  handoff_t          hsState;
  logic              cfgSel;
  logic              mismatch;

  // per-bit masked update
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_comb begin
      regNext[b] = regQ[b];
      if (wrEn && wrData[b+DATA_W]) regNext[b] = wrData[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) regQ <= '0;
    else       regQ <= regNext;
  end

  assign cfgSel   = regQ[MUX_SHIFT];
  assign cfgDiv   = regQ[DIV_SHIFT +: DIV_WIDTH];
  assign ctlWord  = regQ;
  assign mismatch = (cfgSel != actSel);

  always_ff @(posedge clk) begin
    if (!rstN) hsState <= HS_RUN;
    else begin
      unique case (hsState)
        HS_RUN:   if (mismatch) hsState <= HS_SYNC1;
        HS_SYNC1: hsState <= HS_SYNC2;
        HS_SYNC2: hsState <= HS_RUN;
        default:  hsState <= HS_RUN;
      endcase
    end
  end

  always_comb begin
    stb.gateOn  = (hsState == HS_RUN) && !mismatch;
    stb.commit  = (hsState == HS_SYNC2);
    stb.nextSel = cfgSel;
  end
endmodule

// File: rtl/clk_sel_div_dp.sv
module clk_sel_div_dp
  import clk_sel_div_pkg::*;
#(
  parameter int DIV_WIDTH = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_stb_t            stb,
  input  logic [DIV_WIDTH-1:0] cfgDiv,
  input  logic                 priEn,
  input  logic                 altEn,
  output logic                 actSel,
  output logic                 outEn
);
  logic [DIV_WIDTH-1:0] cnt;
  logic [DIV_WIDTH-1:0] actDiv;
  logic                 srcPulse;
  logic                 hit;
  logic                 wrap;

  assign srcPulse = actSel ? altEn : priEn;
  assign hit      = stb.gateOn && srcPulse;
  assign wrap     = hit && (cnt == actDiv);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actSel <= 1'b0;
      cnt    <= '0;
      actDiv <= '0;
      outEn  <= 1'b0;
    end else if (stb.commit) begin
      actSel <= stb.nextSel;
      cnt    <= '0;
      actDiv <= cfgDiv;
      outEn  <= 1'b0;
    end else begin
      outEn <= wrap;
      if (wrap) begin
        cnt    <= '0;
        actDiv <= cfgDiv;   // new divisor only at a period boundary
      end else if (hit) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_sel_div.sv
module clk_sel_div
  import clk_sel_div_pkg::*;
#(
  parameter int DIV_SHIFT = 0,
  parameter int DIV_WIDTH = 4,
  parameter int MUX_SHIFT = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        priEn,
  input  logic        altEn,
  output logic        clkEnOut,
  output logic        selActive
);
  ctrl_stb_t            stb;
  logic [15:0]          ctlWord;
  logic [DIV_WIDTH-1:0] cfgDiv;
  logic                 actSel;

  clk_sel_div_ctrl #(
    .DIV_SHIFT(DIV_SHIFT), .DIV_WIDTH(DIV_WIDTH), .MUX_SHIFT(MUX_SHIFT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .actSel(actSel), .ctlWord(ctlWord), .cfgDiv(cfgDiv), .stb(stb)
  );

  clk_sel_div_dp #(.DIV_WIDTH(DIV_WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgDiv(cfgDiv),
    .priEn(priEn), .altEn(altEn), .actSel(actSel), .outEn(clkEnOut)
  );

  assign rdData    = {16'h0000, ctlWord};
  assign selActive = actSel;
endmodule

// File: rtl/clk_sel_div_chk.sv
module clk_sel_div_chk #(
  parameter int MUX_SHIFT = 6
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic        priEn,
  input logic        altEn,
  input logic        clkEnOut,
  input logic        selActive
);
  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[31:16] == 16'h0000);

  // R2
  masked_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData[15:0] ==
      (($past(rdData[15:0]) & ~$past(wrData[31:16])) |
       ($past(wrData[15:0]) & $past(wrData[31:16]))));

  // R2
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData));

  // R5
  active_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkEnOut |-> ($past(selActive) ? $past(altEn) : $past(priEn)));

  // R6
  swap_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selActive != $past(selActive)) |-> (!clkEnOut && !$past(clkEnOut)));

  // R6
  handoff_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[MUX_SHIFT+16] && (selActive == rdData[MUX_SHIFT]) &&
     (wrData[MUX_SHIFT] != rdData[MUX_SHIFT]))
    |=> ##1 !clkEnOut ##1 !clkEnOut ##1 !clkEnOut);
endmodule

bind clk_sel_div clk_sel_div_chk #(.MUX_SHIFT(MUX_SHIFT)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .priEn(priEn), .altEn(altEn), .clkEnOut(clkEnOut), .selActive(selActive)
);

// File: tb/clk_sel_div_tb.sv
module clk_sel_div_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        priEn = 1'b0;
  logic        altEn = 1'b0;
  logic        clkEnOut;
  logic        selActive;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clk_sel_div u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .priEn(priEn), .altEn(altEn), .clkEnOut(clkEnOut), .selActive(selActive)
  );

  // masked write vectors and expected readback (R2, R3)
  localparam logic [31:0] VEC_WR [6] = '{
    32'h00FF_00A5, 32'hFF00_1200, 32'h0000_FFFF,
    32'h0F0F_0000, 32'h8001_FFFF, 32'hFFFF_0000 };
  localparam logic [31:0] VEC_RD [6] = '{
    32'h0000_00A5, 32'h0000_12A5, 32'h0000_12A5,
    32'h0000_10A0, 32'h0000_90A1, 32'h0000_0000 };

  localparam logic [7:0] SW_OUT = 8'b1010_0001;  // index 0 in bit 0
  localparam logic [7:0] SW_SEL = 8'b1111_1000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // n cycles of source pulses (period 0 = off); counts output pulses
  task automatic runSrc(input int n, input int pp, input int ap, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      priEn = (pp != 0) && (i % pp == 0);
      altEn = (ap != 0) && (i % ap == 0);
      @(negedge clk);
      if (clkEnOut) cnt++;
    end
    priEn = 1'b0; altEn = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset word", rdData, 32'h0);
    check("R1 reset parent", {31'b0, selActive}, 32'h0);

    for (int v = 0; v < 6; v++) begin
      doWrite(VEC_WR[v]);
      check("R2 masked write readback", rdData, VEC_RD[v]);
    end
    check("R3 upper half zero", {16'h0, rdData[31:16]}, 32'h0);
    runSrc(4, 0, 0, n);

    runSrc(6, 1, 0, n);
    check("R1 divide by one", n, 6);
    runSrc(6, 0, 1, n);
    check("R5 alternate ignored while primary", n, 0);

    doWrite(32'h000F_0002);
    runSrc(10, 1, 0, n);
    check("R4 div 2 dense", n, 4);
    runSrc(12, 2, 0, n);
    check("R4 div 2 sparse", n, 2);

    doWrite(32'h000F_0003);
    runSrc(3, 1, 0, n);
    check("R8 old period completes", n, 1);
    runSrc(8, 1, 0, n);
    check("R8 new divisor after boundary", n, 2);
    runSrc(1, 1, 0, n);
    doWrite(32'h000F_0000);
    runSrc(3, 1, 0, n);
    check("R8 mid-period write keeps period", n, 1);
    runSrc(2, 1, 0, n);
    check("R8 divisor 0 after boundary", n, 2);

    // combined parent + divisor write with both parents pulsing
    @(negedge clk);
    priEn = 1'b1; altEn = 1'b1; wrEn = 1'b1; wrData = 32'h004F_0041;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      wrEn = 1'b0;
      check($sformatf("R6 R7 out cycle %0d", c), {31'b0, clkEnOut}, {31'b0, SW_OUT[c]});
      check($sformatf("R6 sel cycle %0d", c), {31'b0, selActive}, {31'b0, SW_SEL[c]});
    end
    priEn = 1'b0; altEn = 1'b0;
    runSrc(6, 1, 0, n);
    check("R5 primary ignored while alternate", n, 0);
    runSrc(4, 0, 1, n);
    check("R5 R7 alternate div 2", n, 2);

    doWrite(32'h0040_0000);
    runSrc(4, 0, 0, n);
    check("R6 back to primary", {31'b0, selActive}, 32'h0);
    runSrc(4, 1, 0, n);
    check("R7 divisor kept on return", n, 2);

    doWrite(32'h000F_000F);
    runSrc(2, 1, 0, n);
    check("R8 boundary before max", n, 1);
    runSrc(32, 1, 0, n);
    check("R4 max divide by 16", n, 2);

    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1 reset mid run word", rdData, 32'h0);
    check("R1 reset mid run parent", {31'b0, selActive}, 32'h0);
    runSrc(3, 1, 0, n);
    check("R1 divide by one after reset", n, 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule